// File: doc/BRIEF.md
# Ethernet Controller Address, Timer and Drop-Count Register Bank

This block is a slice of the control registers of an Ethernet controller. It sits on a simple synchronous host register bus. Each access carries a byte address, a write flag and four byte enables, so byte, word and doubleword accesses are all possible. The slice holds three kinds of register. The first is the six-byte station address together with the eight-byte multicast hash filter, which the receive filter reads. The second is a free-running 32-bit timer. The third is a 24-bit counter of frames that were thrown away because the receive FIFO overflowed.

The station address is first loaded from an EEPROM autoload pulse. Software may later change it, and it also programs the multicast filter. Both of these registers accept only complete doubleword writes; any narrower write leaves them untouched. The timer and the drop counter ignore the data that is written to them. Any write to either of them clears it. The drop counter is also cleared by a software reset, and it holds at its maximum instead of wrapping. Read data is registered and appears one clock after the read is issued.

Top module: `nic_regbank`

## Requirements
- R1: The station address byte k (k = 0..5) is held at byte offset k, on byte lane k mod 4 of the doubleword at offset 0x00 or 0x04. After reset all six bytes are zero. An `ee_load` pulse loads byte k from `ee_mac[8k+7:8k]`.
- R2: The multicast filter byte k (k = 0..7) is held at byte offset 0x08+k, on lane k mod 4. It resets to zero.
- R3: A write to offset 0x00, 0x04, 0x08 or 0x0C changes the station address or filter only when `bus_be` is 4'b1111. A write with any other byte enable pattern leaves the stored bytes unchanged.
- R4: Read data appears on `bus_rdata` after the clock edge that samples the read. It holds its value until the next read. Byte lanes whose enable is low read as zero.
- R5: Lanes 2 and 3 at offset 0x04 are reserved, and so is every doubleword offset that is not mapped. They read as zero and ignore writes.
- R6: The timer at offset 0x48 advances by one on every clock. A write with any data and any byte enables sets it to zero at that edge, and it counts up again from there.
- R7: The drop counter at offset 0x4C advances by one on each clock edge where `drop_pulse` is high. Bits 31:24 of its read data are always zero.
- R8: The drop counter holds at its all-ones value (0xFFFFFF) and does not wrap.
- R9: A write to offset 0x4C or a `soft_rst` pulse clears the drop counter. The clear wins over a `drop_pulse` in the same cycle. A software reset leaves the station address and the filter unchanged.
- R10: `station_addr` and `mcast_filter` always show the stored bytes, with byte k in bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| soft_rst | input | 1 | Software reset pulse; clears the drop counter |
| bus_valid | input | 1 | An access is presented in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored and lanes are chosen by the byte enables |
| bus_be | input | 4 | Byte enables, bit i selects byte lane i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ee_load | input | 1 | Pulse: load the station address from the EEPROM value |
| ee_mac | input | 48 | Station address delivered by the EEPROM autoload |
| drop_pulse | input | 1 | One cycle high per frame dropped on receive FIFO overflow |
| station_addr | output | 48 | Current station address |
| mcast_filter | output | 64 | Current multicast hash filter |

## Verification
The frame-drop increment and the clearing write to the counter can land on the same clock edge. The bench provokes this by raising `drop_pulse` in the very cycle that a write to offset 0x4C is issued. It then reads the counter back and expects zero, since the clear must win. A second instance, with a narrow counter, is driven past its maximum to show that the counter saturates. A write to the timer is followed by reads at known cycle distances, and the bench expects exact counts from those reads.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  localparam int unsigned BUS_DW    = 32;
  localparam int unsigned BUS_LANES = BUS_DW / 8;

  // byte offsets of the mapped doublewords
  localparam logic [7:0] OFS_SA_LO = 8'h00;
  localparam logic [7:0] OFS_SA_HI = 8'h04;
  localparam logic [7:0] OFS_MC_LO = 8'h08;
  localparam logic [7:0] OFS_MC_HI = 8'h0C;
  localparam logic [7:0] OFS_TMR   = 8'h48;
  localparam logic [7:0] OFS_DROP  = 8'h4C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SA_LO,
    SEL_SA_HI,
    SEL_MC_LO,
    SEL_MC_HI,
    SEL_TMR,
    SEL_DROP
  } reg_sel_e;

  function automatic logic [BUS_DW-1:0] lane_mask(input logic [BUS_LANES-1:0] be);
    logic [BUS_DW-1:0] m;
    for (int i = 0; i < BUS_LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/nic_addr_store.sv
module nic_addr_store #(
  parameter int unsigned NWORDS      = 2,
  parameter int unsigned VALID_BYTES = 6,
  localparam int unsigned NBYTES     = NWORDS * 4,
  localparam int unsigned STORE_W    = NBYTES * 8
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NWORDS-1:0]  wr_word,   // already qualified as full-doubleword write
  input  logic [31:0]        wdata,
  input  logic               load,
  input  logic [STORE_W-1:0] load_data,
  output logic [STORE_W-1:0] store_o
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (b < VALID_BYTES) begin : g_live
      logic [7:0] byte_q;
      logic [7:0] byte_d;
      logic       byte_en;

      assign byte_en = load | wr_word[b/4];

      always_comb begin
        byte_d = byte_q;
        if (load)             byte_d = load_data[b*8 +: 8];
        else if (wr_word[b/4]) byte_d = wdata[(b%4)*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)      byte_q <= '0;
        else if (byte_en) byte_q <= byte_d;
      end

      assign store_o[b*8 +: 8] = byte_q;

      // R3: no write and no load means the stored byte is untouched
      a_r3_byte_hold: assert property (@(posedge clk) disable iff (!rst_ni)
        (!load && !wr_word[b/4]) |=> $stable(store_o[b*8 +: 8]));
      // R1: a load takes the autoload value
      a_r1_load_value: assert property (@(posedge clk) disable iff (!rst_ni)
        load |=> (store_o[b*8 +: 8] == $past(load_data[b*8 +: 8])));
    end else begin : g_pad
      assign store_o[b*8 +: 8] = '0;
    end
  end

endmodule

// File: rtl/nic_free_timer.sv
module nic_free_timer #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  output logic [TMR_W-1:0] count_o
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R6: restart from zero on a write
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count_o == '0));
  // R6: one step per clock otherwise
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr |=> (count_o == $past(count_o) + TMR_W'(1)));

endmodule

// File: rtl/nic_drop_counter.sv
module nic_drop_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign cnt_en = clr | (inc & ~at_max);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R9: clear wins over a simultaneous increment
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (count_o == '0));
  // R8: never wraps from full
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && count_o == CNT_MAX) |=> (count_o == CNT_MAX));
  // R7: one step per dropped frame below the ceiling
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && inc && count_o != CNT_MAX) |=> (count_o == $past(count_o) + CNT_W'(1)));
  // R7: idle counter holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr && !inc) |=> $stable(count_o));

endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DROP_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ee_load,
  input  logic [47:0]       ee_mac,
  input  logic              drop_pulse,
  output logic [47:0]       station_addr,
  output logic [63:0]       mcast_filter
);

  localparam int unsigned TMR_W    = BUS_DW;
  localparam int unsigned SA_WORDS = 2;
  localparam int unsigned MC_WORDS = 2;
  localparam int unsigned SA_BYTES = 6;
  localparam int unsigned MC_BYTES = MC_WORDS * 4;
  localparam int unsigned DROP_PAD = BUS_DW - DROP_W;

  // ---------------- reset synchronizer ----------------
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // ---------------- decode ----------------
  logic [ADDR_W-1:0] word_base;
  reg_sel_e          sel;
  logic              acc_wr, acc_rd, full_word;

  assign word_base = {bus_addr[ADDR_W-1:2], 2'b00};
  assign acc_wr    = bus_valid & bus_write;
  assign acc_rd    = bus_valid & ~bus_write;
  assign full_word = (bus_be == 4'b1111);

  always_comb begin
    sel = SEL_NONE;
    if      (word_base == ADDR_W'(OFS_SA_LO)) sel = SEL_SA_LO;
    else if (word_base == ADDR_W'(OFS_SA_HI)) sel = SEL_SA_HI;
    else if (word_base == ADDR_W'(OFS_MC_LO)) sel = SEL_MC_LO;
    else if (word_base == ADDR_W'(OFS_MC_HI)) sel = SEL_MC_HI;
    else if (word_base == ADDR_W'(OFS_TMR))   sel = SEL_TMR;
    else if (word_base == ADDR_W'(OFS_DROP))  sel = SEL_DROP;
  end

  logic [SA_WORDS-1:0] sa_wr;
  logic [MC_WORDS-1:0] mc_wr;
  logic                tmr_clr, drop_clr;

  assign sa_wr    = {acc_wr & full_word & (sel == SEL_SA_HI),
                     acc_wr & full_word & (sel == SEL_SA_LO)};
  assign mc_wr    = {acc_wr & full_word & (sel == SEL_MC_HI),
                     acc_wr & full_word & (sel == SEL_MC_LO)};
  assign tmr_clr  = acc_wr & (sel == SEL_TMR);
  assign drop_clr = (acc_wr & (sel == SEL_DROP)) | soft_rst;

  // ---------------- storage ----------------
  logic [SA_WORDS*32-1:0] sa_store;
  logic [MC_WORDS*32-1:0] mc_store;
  logic [TMR_W-1:0]       tmr_val;
  logic [DROP_W-1:0]      drop_val;

  nic_addr_store #(.NWORDS(SA_WORDS), .VALID_BYTES(SA_BYTES)) u_sa (
    .clk      (clk),
    .rst_ni   (rst_sync_q),
    .wr_word  (sa_wr),
    .wdata    (bus_wdata),
    .load     (ee_load),
    .load_data({{(SA_WORDS*32-48){1'b0}}, ee_mac}),
    .store_o  (sa_store)
  );

  nic_addr_store #(.NWORDS(MC_WORDS), .VALID_BYTES(MC_BYTES)) u_mc (
    .clk      (clk),
    .rst_ni   (rst_sync_q),
    .wr_word  (mc_wr),
    .wdata    (bus_wdata),
    .load     (1'b0),
    .load_data('0),
    .store_o  (mc_store)
  );

  nic_free_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_ni (rst_sync_q),
    .clr    (tmr_clr),
    .count_o(tmr_val)
  );

  nic_drop_counter #(.CNT_W(DROP_W)) u_drop (
    .clk    (clk),
    .rst_ni (rst_sync_q),
    .clr    (drop_clr),
    .inc    (drop_pulse),
    .count_o(drop_val)
  );

  assign station_addr = sa_store[47:0];
  assign mcast_filter = mc_store;

  // ---------------- read path ----------------
  logic [31:0] rd_raw, rdata_d, rdata_q;

  always_comb begin
    unique case (sel)
      SEL_SA_LO: rd_raw = sa_store[31:0];
      SEL_SA_HI: rd_raw = sa_store[63:32];
      SEL_MC_LO: rd_raw = mc_store[31:0];
      SEL_MC_HI: rd_raw = mc_store[63:32];
      SEL_TMR:   rd_raw = tmr_val;
      SEL_DROP:  rd_raw = {{DROP_PAD{1'b0}}, drop_val};
      default:   rd_raw = '0;
    endcase
    rdata_d = rd_raw & lane_mask(bus_be);
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  rdata_q <= '0;
    else if (acc_rd)  rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R4: read data only moves on a read
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !acc_rd |=> $stable(bus_rdata));
  // R5: unmapped doublewords read as zero
  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
  // R7: top byte of the drop counter reads zero
  a_r7_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc_rd && sel == SEL_DROP) |=> (bus_rdata[31:24] == 8'h00));
  // R9: software reset does not disturb the station address
  a_r9_sa_kept: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (soft_rst && !ee_load && !(acc_wr && full_word)) |=> $stable(station_addr));

endmodule

// File: tb/nic_regbank_tb.sv
module nic_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata, s_rdata;
  logic        ee_load;
  logic [47:0] ee_mac;
  logic        drop_pulse;
  logic [47:0] station_addr, s_sa;
  logic [63:0] mcast_filter, s_mc;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];
  bit          chk_pending = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nic_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ee_load(ee_load), .ee_mac(ee_mac), .drop_pulse(drop_pulse),
    .station_addr(station_addr), .mcast_filter(mcast_filter)
  );

  // narrow counter instance sharing the bus, used for saturation
  nic_regbank #(.DROP_W(6)) u_sat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(s_rdata),
    .ee_load(ee_load), .ee_mac(ee_mac), .drop_pulse(drop_pulse),
    .station_addr(s_sa), .mcast_filter(s_mc)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read one clock after it was sampled
  always @(negedge clk) begin
    if (chk_pending) begin
      if (q_exp.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, got %h expected none", bus_rdata);
      end else begin
        check({32'h0, bus_rdata}, {32'h0, q_exp.pop_front()}, q_tag.pop_front());
      end
    end
    chk_pending = bus_valid && !bus_write && rst_n;
  end

  // driver: one access, then the bus goes idle
  task automatic bus_op(input bit wr, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [31:0] exp,
                        input string tag, input bit drop);
    @(posedge clk); #2;
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    drop_pulse = drop;
    if (!wr) begin q_exp.push_back(exp); q_tag.push_back(tag); end
    @(posedge clk); #2;
    bus_valid = 1'b0; bus_write = 1'b0; drop_pulse = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_op(1'b1, a, be, d, 32'h0, "", 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, input logic [31:0] exp,
                    input string tag);
    bus_op(1'b0, a, be, 32'h0, exp, tag, 1'b0);
  endtask

  task automatic drops(input int n);
    @(posedge clk); #2; drop_pulse = 1'b1;
    repeat (n) @(posedge clk);
    #2; drop_pulse = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0; ee_load = 1'b0; ee_mac = '0;
    drop_pulse = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state
    check({16'h0, station_addr}, 64'h0, "R10 station_addr after reset");
    check(mcast_filter, 64'h0, "R10 mcast_filter after reset");
    rd(8'h00, 4'hF, 32'h0, "R1 station low word after reset");

    // EEPROM autoload
    @(posedge clk); #2; ee_load = 1'b1; ee_mac = 48'h6655_4433_2211;
    @(posedge clk); #2; ee_load = 1'b0;
    rd(8'h00, 4'hF, 32'h4433_2211, "R1 autoload low word");
    rd(8'h04, 4'hF, 32'h0000_6655, "R1 autoload high word, R5 reserved lanes");
    check({16'h0, station_addr}, 64'h6655_4433_2211, "R10 station_addr after autoload");

    // partial writes ignored, full write taken
    wr(8'h00, 4'b0011, 32'hDEAD_BEEF);
    rd(8'h00, 4'hF, 32'h4433_2211, "R3 word write to station ignored");
    wr(8'h00, 4'hF, 32'hA1B2_C3D4);
    rd(8'h00, 4'hF, 32'hA1B2_C3D4, "R3 full write to station");
    wr(8'h04, 4'hF, 32'hFFFF_7788);
    rd(8'h04, 4'hF, 32'h0000_7788, "R5 reserved lanes at 0x04 ignore write");
    wr(8'h30, 4'hF, 32'h1234_5678);
    rd(8'h30, 4'hF, 32'h0, "R5 unmapped offset reads zero");

    // multicast filter
    wr(8'h08, 4'hF, 32'h0102_0304);
    wr(8'h0C, 4'hF, 32'h0506_0708);
    wr(8'h0C, 4'b1100, 32'hFFFF_FFFF);
    rd(8'h0C, 4'b0100, 32'h0006_0000, "R4 single lane read, R3 word write to filter ignored");
    rd(8'h08, 4'hF, 32'h0102_0304, "R2 filter low word");
    check(mcast_filter, 64'h0506_0708_0102_0304, "R10 mcast_filter");
    rd(8'h05, 4'b0010, 32'h0000_7700, "R4 byte read of station byte 5");

    // timer: write clears at its edge, reads two and four edges later
    wr(8'h48, 4'b0001, 32'h1234_5678);
    rd(8'h48, 4'hF, 32'd1, "R6 timer one clock after restart");
    rd(8'h48, 4'hF, 32'd3, "R6 timer three clocks after restart");

    // drop counter
    drops(100);
    rd(8'h4C, 4'hF, 32'd100, "R7 drop count after 100 frames");
    check({32'h0, s_rdata}, 64'd63, "R8 narrow counter saturates");
    bus_op(1'b1, 8'h4C, 4'b0001, 32'hFFFF_FFFF, 32'h0, "", 1'b1);
    rd(8'h4C, 4'hF, 32'd0, "R9 clear wins over same-cycle drop");
    check({32'h0, s_rdata}, 64'd0, "R9 narrow counter cleared with concurrent drop");
    drops(5);
    @(posedge clk); #2; soft_rst = 1'b1;
    @(posedge clk); #2; soft_rst = 1'b0;
    rd(8'h4C, 4'hF, 32'd0, "R9 soft reset clears drop counter");
    rd(8'h00, 4'hF, 32'hA1B2_C3D4, "R9 soft reset keeps station address");
    drops(3);
    rd(8'h4C, 4'b0001, 32'd3, "R7 count restarts after clear");

    @(posedge clk); @(posedge clk);
    if (q_exp.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL scoreboard: got %0d unchecked reads expected 0", q_exp.size());
    end
    finish_run();
  end

endmodule